// File: doc/BRIEF.md
# GPIO Port with Separate Edge Flags

This block is a byte-wide, register-mapped general-purpose I/O port. Four lines are fixed outputs and four are fixed inputs. A small synchronous read/write bus with a 3-bit byte address reaches a direction byte, a data byte, an interrupt configuration byte and an interrupt status byte. The output pins are driven from the low half of the data byte. The inputs pass through a synchroniser, and a data read returns their live levels.

Every input line keeps two sticky flags: one for rising edges and one for falling edges. Both flags latch whatever the line's trigger setting is. A 2-bit field for each line in the configuration byte picks which flag appears in the status byte, or hides both. A single level interrupt output is high while any visible status bit is set. Writing a 1 to a status bit clears both hidden flags of that line. A driver can therefore clear a line and then re-aim its trigger without losing an edge that arrives later.

Top module: `gpio_edge_port`

## Requirements
- R1: Offset 0 is the direction byte. It resets to 0x0F and reads back the last value written. Its contents never change which lines are inputs or outputs.
- R2: A write to offset 1 drives data bits 3:0 onto `gpo_o` from the next clock edge, and the pins hold that value until the next such write. A read of offset 1 returns 0 in bits 3:0.
- R3: A read of offset 1 returns the input levels in bits 7:4, with `gpi_i[k]` in bit 4+k. A change on `gpi_i` shows there after two clock edges.
- R4: Offset 3 is the configuration byte and reads back as written. Input k is controlled by bits [2k+1:2k]: 00 is off, 01 selects falling edges, 10 selects rising edges, and 11 counts as off.
- R5: Each input has a rising flag and a falling flag. A flag is set by an edge between consecutive synchronised samples, with the setting taking effect three clock edges after the pin changes. Both flags are set whatever the configuration, and a flag stays set until it is cleared.
- R6: A read of offset 4 returns the flag that field k selects in bit k, and 0 in bits 7:4. `irq_o` is high exactly when any of these bits is 1.
- R7: Writing offset 4 with bit k set clears both flags of input k. Bits written as 0 leave their flags unchanged.
- R8: If a clear and a new edge on the same input fall in the same cycle, the flag of the new edge stays set.
- R9: After reset, `gpo_o`, the configuration byte, all flags and `irq_o` are 0.
- R10: Offsets 2, 5, 6 and 7 read as 0. Writes to them change no register, flag or pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Byte address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| gpo_o | output | 4 | Output pins |
| gpi_i | input | 4 | Input pins, asynchronous |
| irq_o | output | 1 | Level interrupt |

## Verification
A register write takes effect at the clock edge that samples it, so output pins and read-back are checked at the falling edge that follows. After an input changes, the data byte is expected to show the change after exactly two rising edges, and the status bit and `irq_o` after three. The bench checks the value one edge early as well as on time, so both an added and a missing stage are caught. For the same-cycle clear case, the status write is raised so that its edge coincides with the third edge after the pin change.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd4;
  localparam logic [1:0] TRIG_OFF  = 2'b00;
  localparam logic [1:0] TRIG_FALL = 2'b01;
  localparam logic [1:0] TRIG_RISE = 2'b10;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_flag.sv
module gpio_edge_flag
  import gpio_edge_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic       clr_i,
  input  logic [1:0] sel_i,
  output logic       vis_o
);
  logic prev_q, rise_q, fall_q;
  logic rise_evt, fall_evt;

  assign rise_evt = lvl_i & ~prev_q;
  assign fall_evt = ~lvl_i & prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      // a fresh edge beats a simultaneous clear
      rise_q <= rise_evt | (rise_q & ~clr_i);
      fall_q <= fall_evt | (fall_q & ~clr_i);
    end
  end

  always_comb begin
    unique case (sel_i)
      TRIG_FALL: vis_o = fall_q;
      TRIG_RISE: vis_o = rise_q;
      default:   vis_o = 1'b0;
    endcase
  end

  p_rise_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_evt |=> rise_q);
  p_rise_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_evt && !clr_i) |=> (rise_q == $past(rise_q)));
  p_clear_both_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !rise_evt && !fall_evt) |=> (!rise_q && !fall_q));
  p_edge_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && fall_evt) |=> fall_q);
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int N_OUT       = 4,
  parameter int N_IN        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  output logic [7:0]        rdata_o,
  output logic [N_OUT-1:0]  gpo_o,
  input  logic [N_IN-1:0]   gpi_i,
  output logic              irq_o
);
  localparam int DATA_W = N_OUT + N_IN;
  localparam int CFG_W  = 2 * N_IN;
  localparam logic [7:0] DIR_RST = 8'((1 << N_OUT) - 1);

  logic [7:0]       dir_q;
  logic [N_OUT-1:0] out_q;
  logic [CFG_W-1:0] cfg_q;
  logic [N_IN-1:0]  lvl_s;
  logic [N_IN-1:0]  stat;
  logic             wr_dir, wr_data, wr_cfg, wr_stat, mapped;

  assign wr_dir  = we_i && (addr_i == OFS_DIR);
  assign wr_data = we_i && (addr_i == OFS_DATA);
  assign wr_cfg  = we_i && (addr_i == OFS_CFG);
  assign wr_stat = we_i && (addr_i == OFS_STAT);
  assign mapped  = (addr_i == OFS_DIR) || (addr_i == OFS_DATA) ||
                   (addr_i == OFS_CFG) || (addr_i == OFS_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= DIR_RST;
      out_q <= '0;
      cfg_q <= '0;
    end else begin
      if (wr_dir)  dir_q <= wdata_i;
      if (wr_data) out_q <= wdata_i[N_OUT-1:0];
      if (wr_cfg)  cfg_q <= wdata_i[CFG_W-1:0];
    end
  end

  gpio_in_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpi_i),
    .q_o   (lvl_s)
  );

  for (genvar k = 0; k < N_IN; k++) begin : g_line
    gpio_edge_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (lvl_s[k]),
      .clr_i (wr_stat && wdata_i[k]),
      .sel_i (cfg_q[2*k +: 2]),
      .vis_o (stat[k])
    );
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_DIR:  rdata_o = dir_q;
      OFS_DATA: rdata_o = 8'({lvl_s, {N_OUT{1'b0}}});
      OFS_CFG:  rdata_o = 8'(cfg_q);
      OFS_STAT: rdata_o = 8'(stat);
      default:  rdata_o = '0;
    endcase
  end

  assign gpo_o = out_q;
  assign irq_o = |stat;

  p_out_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_data |=> $stable(gpo_o));
  p_unmapped_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !mapped) |=> ($stable(cfg_q) && $stable(dir_q) && $stable(gpo_o)));
  p_width_r1: assert property (@(posedge clk_i) DATA_W <= 8);
endmodule

// File: tb/gpio_edge_port_tb.sv
module gpio_edge_port_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] rdata_o;
  logic [3:0] gpo_o;
  logic [3:0] gpi_i = '0;
  logic       irq_o;

  int checks = 0;
  int errors = 0;

  logic [3:0] m_rise = '0, m_fall = '0, m_in = '0;
  logic [7:0] m_cfg = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_edge_port u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .rdata_o(rdata_o), .gpo_o(gpo_o), .gpi_i(gpi_i), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_stat();
    logic [3:0] s = '0;
    for (int k = 0; k < 4; k++) begin
      case (m_cfg[2*k +: 2])
        2'b01: s[k] = m_fall[k];
        2'b10: s[k] = m_rise[k];
        default: s[k] = 1'b0;
      endcase
    end
    return s;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic set_cfg(input logic [7:0] c);
    wr(3'd3, c); m_cfg = c;
  endtask

  task automatic clr(input logic [3:0] m);
    wr(3'd4, {4'h0, m}); m_rise &= ~m; m_fall &= ~m;
  endtask

  task automatic chk_stat(input string tag);
    logic [7:0] d;
    rd(3'd4, d);
    chk(tag, d, {4'h0, exp_stat()});
    chk({tag, " irq"}, irq_o, |exp_stat());
  endtask

  // drive inputs and check R3/R5/R6 latency one edge early and on time
  task automatic set_in(input logic [3:0] v);
    logic [7:0] d;
    logic [3:0] old_in = m_in;
    logic [3:0] old_stat = exp_stat();
    gpi_i = v;
    @(negedge clk_i);
    rd(3'd1, d); chk("R3 data before sync", d, {old_in, 4'h0});
    @(negedge clk_i);
    rd(3'd1, d); chk("R3 data after 2 edges", d, {v, 4'h0});
    rd(3'd4, d); chk("R5 status not yet set", d, {4'h0, old_stat});
    @(negedge clk_i);
    m_rise |= v & ~old_in;
    m_fall |= ~v & old_in;
    m_in = v;
    chk_stat("R6 status after 3 edges");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 reset state
    chk("R9 gpo", gpo_o, 0);
    chk("R9 irq", irq_o, 0);
    rd(3'd3, d); chk("R9 cfg", d, 0);
    rd(3'd4, d); chk("R9 status", d, 0);
    rd(3'd0, d); chk("R1 dir reset", d, 8'h0F);

    // R1 direction byte read-back, no effect on pins
    for (int v = 0; v < 256; v += 51) begin
      wr(3'd0, 8'(v));
      rd(3'd0, d); chk("R1 dir readback", d, v);
    end
    wr(3'd1, 8'hA5);
    chk("R1 outputs still drive", gpo_o, 4'h5);

    // R2 outputs
    for (int v = 0; v < 16; v++) begin
      wr(3'd1, {4'hF, 4'(v)});
      chk("R2 gpo", gpo_o, v);
      rd(3'd1, d); chk("R2 data low bits zero", d[3:0], 0);
    end

    // R4 config read-back
    for (int v = 0; v < 256; v += 17) begin
      set_cfg(8'(v));
      rd(3'd3, d); chk("R4 cfg readback", d, v);
    end
    set_cfg(8'h00);

    // R4/R5/R6/R7 sweep: each line, each code, both edges
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 4; c++) begin
        clr(4'hF);
        set_cfg(8'(c << (2*k)));
        chk_stat("R7 status after clear");
        set_in(m_in ^ 4'(1 << k));
        set_in(m_in ^ 4'(1 << k));
      end
    end

    // R5 hidden flag: rising latched while falling selected
    set_in(4'h0);
    clr(4'hF);
    set_cfg(8'h01);
    set_in(4'h1);
    chk("R5 hidden rise not visible", irq_o, 0);
    set_cfg(8'h02);
    chk_stat("R5 hidden rise shows on reselect");
    chk("R5 irq after reselect", irq_o, 1);

    // R7 clear drops both flags; zero bits untouched
    set_cfg(8'hAA);
    set_in(4'hF);
    set_in(4'hE);
    clr(4'h1);
    set_cfg(8'h55);
    chk_stat("R7 falling also cleared");
    clr(4'h0);
    chk_stat("R7 zero mask no effect");
    set_cfg(8'hAA);
    chk_stat("R7 other rising flags kept");

    // R10 unmapped offsets
    wr(3'd0, 8'h3C);
    for (int a = 2; a < 8; a++) begin
      if (a == 3 || a == 4) continue;
      wr(3'(a), 8'hFF);
      rd(3'(a), d); chk("R10 unmapped read", d, 0);
    end
    rd(3'd0, d); chk("R10 dir untouched", d, 8'h3C);
    rd(3'd3, d); chk("R10 cfg untouched", d, 8'hAA);
    chk("R10 gpo untouched", gpo_o, 4'hF);
    chk_stat("R10 status untouched");

    // R8 clear coincides with new edge
    set_in(4'h0);
    clr(4'hF);
    set_cfg(8'h02);
    gpi_i = 4'h1;
    @(negedge clk_i);
    @(negedge clk_i);
    wr(3'd4, 8'h01);
    m_in = 4'h1; m_rise = 4'h1; m_fall = '0;
    chk_stat("R8 edge wins over clear");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule